// File: doc/BRIEF.md
# ADC Conversion Sequencer

This block is a register-programmed controller that sits between a processor register bus and an external 10-bit successive-approximation converter. Software writes one 8-bit control word. The word selects the input channel, the sampling rate, converter power, result width and a start request. The block divides the system clock into a periodic sample tick. On a tick it issues a one-cycle start strobe to the converter. It then waits for the converter's completion flag and places the conversion result into two readable result registers.

The start bit is owned by hardware once set. It stays at 1 for the whole conversion and falls on its own when the result registers update. A one-cycle completion pulse marks that update. The sample tick period doubles with each step of the rate field. It doubles once more when the system runs from its slowest clock setting, which is signalled on a dedicated input.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset the control word reads 0x00. The result registers read 0. The start strobe, completion pulse, sample tick and power output are all 0.
- R2: The control word is laid out as channel in bits 7:5, rate in bits 4:3, power in bit 2, width in bit 1 and start in bit 0. Every field written reads back unchanged, apart from the start bit rules in R5 and R7.
- R3: While power is on, the sample tick is a one-cycle pulse. Its period is 2^(BASE_EXP + rate + slow) cycles, where slow is the slow-clock input (0 or 1) and BASE_EXP defaults to 2.
- R4: While power is off, the sample tick and the start strobe stay at 0.
- R5: If a write sets start while the written power bit is 0, the request is ignored. The start bit reads 0 and no start strobe is issued.
- R6: A pending start produces exactly one start strobe. The strobe comes in the cycle after a sample tick. The channel output carries the channel that was latched for this conversion.
- R7: When the converter reports done, the result registers, the completion pulse and the clearing of the start bit all take effect on the same clock edge. The pulse lasts one cycle.
- R8: With width bit 1, the main register holds result bits 9:2. Bits 7:6 of the extension register hold result bits 1:0, and bits 5:0 of the extension register read 0.
- R9: With width bit 0, the main register holds result bits 9:2 and the extension register reads 0.
- R10: If the channel or width fields are written during a conversion, the running conversion keeps the values it latched. The new values apply only from the next conversion. A start value written during a conversion is ignored.
- R11: The power output follows the stored power bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctrl_we | input | 1 | Control word write strobe |
| ctrl_wdata | input | 8 | Control word write data |
| slow_clk | input | 1 | 1 when the system runs from its slowest clock setting |
| adc_done_i | input | 1 | Converter completion flag |
| adc_data_i | input | ADC_W | Converter result |
| ctrl_q | output | 8 | Control word read value |
| res_main_o | output | RES_W | Main result register |
| res_ext_o | output | RES_W | Extension result register (low bits in the top bits) |
| done_pulse_o | output | 1 | One-cycle pulse when the result registers update |
| samp_en_o | output | 1 | Sample tick |
| adc_pwr_o | output | 1 | Converter power enable |
| adc_start_o | output | 1 | One-cycle converter start strobe |
| adc_chan_o | output | 3 | Channel latched for the current conversion |

## Verification
Random conversions mix all eight channels, both result widths and random 10-bit data. Each result is compared with a bench function, so a swapped or shifted bit field in either mapping is caught. Tick periods are measured for every rate code at both clock-range settings, which separates the rate step from the slow-clock step. Directed cases cover three situations: a start request with power off, fields rewritten during a conversion (old latched values must be kept for that conversion), and the conversion that follows (new values must be used).

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
   localparam int CHAN_W = 3;
   localparam int RATE_W = 2;
   localparam int CTRL_W = CHAN_W + RATE_W + 3;

   typedef struct packed {
      logic [CHAN_W-1:0] chan;
      logic [RATE_W-1:0] rate;
      logic              pwr;
      logic              wide;
      logic              start;
   } ctrl_t;

   typedef enum logic {
      SEQ_IDLE = 1'b0,
      SEQ_CONV = 1'b1
   } seq_state_t;
endpackage

// File: rtl/adc_rate_div.sv
module adc_rate_div #(
   parameter int BASE_EXP = 2,
   parameter int RATE_W   = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic [RATE_W-1:0] rate,
   input  logic              slow,
   output logic              tick
);
   localparam int MAX_EXP = BASE_EXP + (2**RATE_W - 1) + 1;
   localparam int CNT_W   = MAX_EXP;

   generate
      if (BASE_EXP < 1) begin : g_bad_base
         $error("adc_rate_div: BASE_EXP must be at least 1");
      end
   endgenerate

   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] term;
   logic [7:0]       shift;

   always_comb begin
      shift = 8'(MAX_EXP - BASE_EXP) - 8'(rate) - 8'(slow);
      term  = {CNT_W{1'b1}} >> shift;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt  <= '0;
         tick <= 1'b0;
      end else if (!run) begin
         cnt  <= '0;
         tick <= 1'b0;
      end else if (cnt >= term) begin
         cnt  <= '0;
         tick <= 1'b0;
      end else begin
         cnt  <= cnt + 1'b1;
         tick <= (cnt + 1'b1) >= term;
      end
   end

   assert_no_tick_unpowered_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(run) |-> !tick);
   assert_tick_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick);
endmodule

// File: rtl/adc_result_fmt.sv
module adc_result_fmt #(
   parameter int ADC_W = 10,
   parameter int RES_W = 8
) (
   input  logic [ADC_W-1:0] data,
   input  logic             wide,
   output logic [RES_W-1:0] main_v,
   output logic [RES_W-1:0] ext_v
);
   localparam int EXT_W = ADC_W - RES_W;

   generate
      if (EXT_W < 0 || EXT_W > RES_W) begin : g_bad_width
         $error("adc_result_fmt: need RES_W <= ADC_W <= 2*RES_W");
      end
   endgenerate

   assign main_v = data[ADC_W-1 -: RES_W];

   generate
      if (EXT_W == 0) begin : g_no_ext
         assign ext_v = '0;
      end else if (EXT_W == RES_W) begin : g_full_ext
         assign ext_v = wide ? data[EXT_W-1:0] : '0;
      end else begin : g_part_ext
         assign ext_v = wide ? {data[EXT_W-1:0], {(RES_W-EXT_W){1'b0}}} : '0;
      end
   endgenerate
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
   import adc_seq_pkg::*;
#(
   parameter int BASE_EXP = 2,
   parameter int ADC_W    = 10,
   parameter int RES_W    = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctrl_we,
   input  logic [7:0]        ctrl_wdata,
   input  logic              slow_clk,
   input  logic              adc_done_i,
   input  logic [ADC_W-1:0]  adc_data_i,
   output logic [7:0]        ctrl_q,
   output logic [RES_W-1:0]  res_main_o,
   output logic [RES_W-1:0]  res_ext_o,
   output logic              done_pulse_o,
   output logic              samp_en_o,
   output logic              adc_pwr_o,
   output logic              adc_start_o,
   output logic [2:0]        adc_chan_o
);
   generate
      if (CTRL_W != 8) begin : g_bad_ctrl
         $error("adc_seq_ctrl: control word must be 8 bits");
      end
   endgenerate

   ctrl_t       ctrl_r, ctrl_d, wr_v;
   seq_state_t  state;
   logic        wide_lat;
   logic        finish;
   logic [RES_W-1:0] fmt_main, fmt_ext;

   assign wr_v   = ctrl_t'(ctrl_wdata);
   assign finish = (state == SEQ_CONV) && ctrl_r.pwr && adc_done_i;

   always_comb begin
      ctrl_d = ctrl_r;
      if (ctrl_we) begin
         ctrl_d       = wr_v;
         ctrl_d.start = ctrl_r.start | (wr_v.start & wr_v.pwr);
      end
      if (!ctrl_d.pwr || finish) ctrl_d.start = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ctrl_r <= '0;
      else        ctrl_r <= ctrl_d;
   end

   adc_rate_div #(.BASE_EXP(BASE_EXP), .RATE_W(RATE_W)) u_div (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (ctrl_r.pwr),
      .rate  (ctrl_r.rate),
      .slow  (slow_clk),
      .tick  (samp_en_o)
   );

   adc_result_fmt #(.ADC_W(ADC_W), .RES_W(RES_W)) u_fmt (
      .data   (adc_data_i),
      .wide   (wide_lat),
      .main_v (fmt_main),
      .ext_v  (fmt_ext)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state        <= SEQ_IDLE;
         adc_start_o  <= 1'b0;
         adc_chan_o   <= '0;
         wide_lat     <= 1'b0;
         res_main_o   <= '0;
         res_ext_o    <= '0;
         done_pulse_o <= 1'b0;
      end else begin
         adc_start_o  <= 1'b0;
         done_pulse_o <= 1'b0;
         unique case (state)
            SEQ_IDLE: begin
               if (ctrl_r.start && ctrl_r.pwr && samp_en_o) begin
                  adc_start_o <= 1'b1;
                  adc_chan_o  <= ctrl_r.chan;
                  wide_lat    <= ctrl_r.wide;
                  state       <= SEQ_CONV;
               end
            end
            SEQ_CONV: begin
               if (!ctrl_r.pwr) begin
                  state <= SEQ_IDLE;
               end else if (adc_done_i) begin
                  res_main_o   <= fmt_main;
                  res_ext_o    <= fmt_ext;
                  done_pulse_o <= 1'b1;
                  state        <= SEQ_IDLE;
               end
            end
            default: state <= SEQ_IDLE;
         endcase
      end
   end

   assign ctrl_q    = ctrl_r;
   assign adc_pwr_o = ctrl_r.pwr;

   assert_start_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
      adc_start_o |=> !adc_start_o);
   assert_start_after_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
      adc_start_o |-> $past(samp_en_o));
   assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done_pulse_o |=> !done_pulse_o);
   assert_start_cleared_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done_pulse_o |-> !ctrl_q[0]);
   assert_no_start_unpowered_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !adc_pwr_o |-> !adc_start_o);
endmodule

// File: tb/sim_adc_seq_ctrl.sv
`timescale 1ns/100ps
module sim_adc_seq_ctrl;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ctrl_we = 1'b0;
   logic [7:0] ctrl_wdata = '0;
   logic       slow_clk = 1'b0;
   logic       adc_done_i = 1'b0;
   logic [9:0] adc_data_i = '0;
   logic [7:0] ctrl_q, res_main_o, res_ext_o;
   logic       done_pulse_o, samp_en_o, adc_pwr_o, adc_start_o;
   logic [2:0] adc_chan_o;

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;
   bit ended  = 1'b0;

   always #2.5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   adc_seq_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
      .slow_clk(slow_clk), .adc_done_i(adc_done_i), .adc_data_i(adc_data_i),
      .ctrl_q(ctrl_q), .res_main_o(res_main_o), .res_ext_o(res_ext_o),
      .done_pulse_o(done_pulse_o), .samp_en_o(samp_en_o), .adc_pwr_o(adc_pwr_o),
      .adc_start_o(adc_start_o), .adc_chan_o(adc_chan_o)
   );

   function automatic logic [7:0] pack(input logic [2:0] ch, input logic [1:0] rt,
                                       input logic pw, input logic wd, input logic st);
      return {ch, rt, pw, wd, st};
   endfunction

   function automatic logic [7:0] exp_ext(input logic [9:0] d, input logic wd);
      return wd ? {d[1:0], 6'b0} : 8'h00;
   endfunction

   task automatic check(input string req, input longint act, input longint expv);
      checks++;
      if (act != expv) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
      end
   endtask

   task automatic wr(input logic [7:0] v);
      @(negedge clk);
      ctrl_we = 1'b1; ctrl_wdata = v;
      @(negedge clk);
      ctrl_we = 1'b0;
   endtask

   task automatic wait_tick(output bit ok);
      int n = 0;
      while (!samp_en_o && n < 300) begin @(negedge clk); n++; end
      ok = samp_en_o;
   endtask

   task automatic measure(input logic [1:0] rt, input logic sl);
      bit ok; int t1;
      slow_clk = sl;
      wr(pack(3'd0, rt, 1'b1, 1'b0, 1'b0));
      wait_tick(ok); @(negedge clk);
      wait_tick(ok); t1 = cyc; @(negedge clk);
      wait_tick(ok);
      check("R3 tick period", ok ? cyc - t1 : -1, 1 << (2 + rt + sl));
   endtask

   task automatic run_conv(input logic [2:0] ch, input logic [1:0] rt, input logic wd,
                           input logic [9:0] d, input bit midwrite);
      bit prev = 1'b0; int n = 0;
      logic [7:0] exp_ctrl;
      wr(pack(ch, rt, 1'b1, wd, 1'b1));
      check("R2 readback with start", ctrl_q, pack(ch, rt, 1'b1, wd, 1'b1));
      while (!adc_start_o && n < 300) begin prev = samp_en_o; @(negedge clk); n++; end
      check("R6 strobe seen", adc_start_o, 1);
      check("R6 strobe after tick", prev, 1);
      check("R6 channel", adc_chan_o, ch);
      @(negedge clk);
      check("R6 strobe one cycle", adc_start_o, 0);
      exp_ctrl = pack(ch, rt, 1'b1, wd, 1'b0);
      if (midwrite) begin
         wr(pack(~ch, rt, 1'b1, ~wd, 1'b0));
         check("R10 start held during conversion", ctrl_q[0], 1);
         exp_ctrl = pack(~ch, rt, 1'b1, ~wd, 1'b0);
      end
      repeat (2) @(negedge clk);
      adc_done_i = 1'b1; adc_data_i = d;
      @(negedge clk);
      adc_done_i = 1'b0;
      check("R7 done pulse", done_pulse_o, 1);
      check("R7 start cleared", ctrl_q, exp_ctrl);
      check(wd ? "R8 main" : "R9 main", res_main_o, d[9:2]);
      check(wd ? "R8 ext" : "R9 ext", res_ext_o, exp_ext(d, wd));
      if (midwrite) check("R10 channel kept", adc_chan_o, ch);
      @(negedge clk);
      check("R7 done one cycle", done_pulse_o, 0);
   endtask

   initial begin
      process p;
      int unused_seed;
      p = process::self();
      unused_seed = $urandom(32'h5eed);
      repeat (3) @(negedge clk);
      check("R1 ctrl", ctrl_q, 0);
      check("R1 results", {res_main_o, res_ext_o}, 0);
      check("R1 outputs", {done_pulse_o, samp_en_o, adc_pwr_o, adc_start_o}, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R5 and R4: start request with power off
      wr(pack(3'd5, 2'd1, 1'b0, 1'b1, 1'b1));
      check("R5 start ignored", ctrl_q, pack(3'd5, 2'd1, 1'b0, 1'b1, 1'b0));
      check("R11 power low", adc_pwr_o, 0);
      begin
         int seen = 0;
         for (int i = 0; i < 80; i++) begin
            @(negedge clk);
            if (samp_en_o || adc_start_o) seen++;
         end
         check("R4 quiet when unpowered", seen, 0);
      end
      wr(pack(3'd2, 2'd3, 1'b1, 1'b0, 1'b0));
      check("R11 power high", adc_pwr_o, 1);
      check("R2 readback", ctrl_q, pack(3'd2, 2'd3, 1'b1, 1'b0, 1'b0));

      for (int r = 0; r < 4; r++) begin
         measure(2'(r), 1'b0);
         measure(2'(r), 1'b1);
      end
      slow_clk = 1'b0;

      // directed: corner data, mid-conversion write, then the next conversion
      run_conv(3'd7, 2'd0, 1'b1, 10'h3ff, 1'b0);
      run_conv(3'd0, 2'd0, 1'b0, 10'h3ff, 1'b0);
      run_conv(3'd3, 2'd1, 1'b1, 10'h001, 1'b1);
      run_conv(3'd4, 2'd1, 1'b0, 10'h2aa, 1'b0);

      for (int i = 0; i < 24; i++) begin
         slow_clk = 1'($urandom);
         run_conv(3'($urandom), 2'($urandom), 1'($urandom), 10'($urandom), 1'($urandom % 4 == 0));
      end

      if (!ended) begin
         ended = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!ended) begin
         ended = 1'b1;
         checks++; fails++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule